// File: doc/BRIEF.md
# Interrupt Driveback Receiver

This block sits on the host side of a peripheral bus. It watches a simple I/O write slave port and claims only the writes aimed at one programmable I/O address. Such a write carries a 32-bit word. The low half holds new levels for sixteen system interrupt lines, and the high half holds an active-low enable for each of those lines. Only the lines whose enable is low take the new level. Every other line keeps its present state. The sixteen resulting levels drive an interrupt controller directly.

A peripheral raises an interrupt by writing a word in which its own lines are enabled and set high. It clears the interrupt later by writing the same lines low. A burst may carry one more data phase after the first. The block claims that phase, holds its word in an auxiliary register and raises a one-cycle flag. That extra word never changes an interrupt line.

Top module: `irq_driveback_rx`

## Requirements
- R1: Once reset is released, every interrupt level output is 0, `aux_valid` is 0, `aux_data` is 0, and the claim address equals the parameter `RESET_ADDR`.
- R2: A first data phase (`io_wr`=1, `io_cont`=0) is claimed, with `io_claim` high in the same cycle, only when `io_addr` equals the current claim address.
- R3: In a claimed first phase, data bit n (n = 0..15) is the new level of `irq_lvl[n]`. The level shows on the outputs from the clock edge that ends that phase.
- R4: Data bit 16+n is an active-low enable for line n. When it is 1, `irq_lvl[n]` keeps its value through the claimed write.
- R5: A first phase to any other address is not claimed and changes no interrupt level and no auxiliary output.
- R6: A continuation phase (`io_cont`=1) that is the next strobe after a claimed first phase is claimed. Its word appears on `aux_data` after the edge, with `aux_valid` high for exactly that one cycle, and no interrupt level changes.
- R7: A continuation phase with no claimed first phase directly before it is not claimed and changes nothing. This covers a third phase, and a continuation after an unclaimed write.
- R8: Asserting `cfg_we` loads `cfg_addr` as the claim address from the next cycle onward. A write in the same cycle is still decoded against the old address.
- R9: `io_claim` is never high while `io_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a new claim address |
| cfg_addr | input | 16 | Claim address to load |
| io_wr | input | 1 | Write data phase strobe |
| io_cont | input | 1 | 1 = continuation phase of the current burst |
| io_addr | input | 16 | I/O address of a first phase |
| io_data | input | 32 | Write data |
| io_claim | output | 1 | Phase is claimed by this block (combinational) |
| irq_lvl | output | 16 | Interrupt line levels |
| aux_data | output | 32 | Word from the last claimed continuation phase |
| aux_valid | output | 1 | One-cycle flag: `aux_data` was just loaded |

## Verification
`io_claim` is combinational, so it is due in the cycle the strobe is driven. The bench drives inputs on the falling edge and compares the claim one time unit later. The interrupt levels, the auxiliary word and its flag pass through one register each, and a new claim address takes effect after one edge. The bench therefore updates its model at the rising edge and compares those outputs one time unit after that edge, before the next stimulus is driven.

// File: rtl/irqdb_pkg.sv
package irqdb_pkg;

   typedef enum logic [1:0] {
      PH_NONE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SECOND = 2'd2
   } phase_e;

   function automatic logic merge_bit(input logic cur, input logic nxt, input logic en_n);
      return en_n ? cur : nxt;
   endfunction

endpackage

// File: rtl/irqdb_claim.sv
module irqdb_claim
   import irqdb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   parameter bit          AUX_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              io_wr,
   input  logic              io_cont,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              io_claim,
   output phase_e            phase
);

   logic [ADDR_W-1:0] match_addr_q;
   logic              armed_q;
   logic              first_hit;
   logic              second_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      match_addr_q <= RESET_ADDR;
      else if (cfg_we) match_addr_q <= cfg_addr;
   end

   assign first_hit = io_wr && !io_cont && (io_addr == match_addr_q);

   generate
      if (AUX_EN) begin : g_second
         assign second_hit = io_wr && io_cont && armed_q;
      end else begin : g_no_second
         assign second_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (io_wr) armed_q <= first_hit;
   end

   always_comb begin
      phase = PH_NONE;
      if (first_hit)       phase = PH_FIRST;
      else if (second_hit) phase = PH_SECOND;
   end

   assign io_claim = first_hit || second_hit;

   p_claim_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      io_claim |-> io_wr);

   p_orphan_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_cont && !armed_q) |-> !io_claim);

   p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (match_addr_q == $past(cfg_addr)));

endmodule

// File: rtl/irqdb_mask_reg.sv
module irqdb_mask_reg
   import irqdb_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd,
   input  logic [NUM_IRQ-1:0] new_lvl,
   input  logic [NUM_IRQ-1:0] en_n,
   output logic [NUM_IRQ-1:0] lvl
);

   generate
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
         logic lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   lvl_q <= 1'b0;
            else if (upd) lvl_q <= merge_bit(lvl_q, new_lvl[i], en_n[i]);
         end

         assign lvl[i] = lvl_q;

         p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && en_n[i]) |=> (lvl[i] == $past(lvl[i])));

         p_enabled_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && !en_n[i]) |=> (lvl[i] == $past(new_lvl[i])));
      end
   endgenerate

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(lvl));

endmodule

// File: rtl/irqdb_aux.sv
module irqdb_aux #(
   parameter int unsigned DATA_W = 32,
   parameter bit          AUX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              fresh
);

   generate
      if (AUX_EN) begin : g_reg
         logic [DATA_W-1:0] data_q;
         logic              fresh_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q  <= '0;
               fresh_q <= 1'b0;
            end else begin
               fresh_q <= take;
               if (take) data_q <= din;
            end
         end

         assign dout  = data_q;
         assign fresh = fresh_q;

         p_take_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> (fresh && dout == $past(din)));

         p_aux_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !take |=> (!fresh && $stable(dout)));
      end else begin : g_none
         assign dout  = '0;
         assign fresh = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/irq_driveback_rx.sv
module irq_driveback_rx
   import irqdb_pkg::*;
#(
   parameter int unsigned NUM_IRQ    = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0C80,
   parameter bit          AUX_EN     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic               io_wr,
   input  logic               io_cont,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic [DATA_W-1:0]  io_data,
   output logic               io_claim,
   output logic [NUM_IRQ-1:0] irq_lvl,
   output logic [DATA_W-1:0]  aux_data,
   output logic               aux_valid
);

   localparam int unsigned EN_LSB = DATA_W / 2;

   generate
      if (NUM_IRQ < 1 || NUM_IRQ > EN_LSB) begin : g_bad_irq
         $error("NUM_IRQ must lie in 1..DATA_W/2");
      end
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("DATA_W must be even");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
   endgenerate

   phase_e phase;

   irqdb_claim #(
      .ADDR_W     (ADDR_W),
      .RESET_ADDR (RESET_ADDR),
      .AUX_EN     (AUX_EN)
   ) u_claim (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .io_wr    (io_wr),
      .io_cont  (io_cont),
      .io_addr  (io_addr),
      .io_claim (io_claim),
      .phase    (phase)
   );

   irqdb_mask_reg #(
      .NUM_IRQ (NUM_IRQ)
   ) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (phase == PH_FIRST),
      .new_lvl (io_data[NUM_IRQ-1:0]),
      .en_n    (io_data[EN_LSB +: NUM_IRQ]),
      .lvl     (irq_lvl)
   );

   irqdb_aux #(
      .DATA_W (DATA_W),
      .AUX_EN (AUX_EN)
   ) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (phase == PH_SECOND),
      .din   (io_data),
      .dout  (aux_data),
      .fresh (aux_valid)
   );

   p_second_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_claim && io_cont) |=> $stable(irq_lvl));

   p_flag_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      aux_valid |=> !aux_valid);

endmodule

// File: tb/irq_driveback_rx_test.sv
module irq_driveback_rx_test;

   localparam logic [15:0] RST_ADDR = 16'h0C80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_cont = 1'b0;
   logic [15:0] io_addr = '0;
   logic [31:0] io_data = '0;
   logic        io_claim;
   logic [15:0] irq_lvl;
   logic [31:0] aux_data;
   logic        aux_valid;

   int n_checks = 0;
   int n_fail   = 0;

   logic [15:0] m_addr  = RST_ADDR;
   logic [15:0] m_irq   = '0;
   logic [31:0] m_aux   = '0;
   logic        m_auxv  = 1'b0;
   logic        m_armed = 1'b0;

   always #4 clk = ~clk;

   irq_driveback_rx uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .io_wr     (io_wr),
      .io_cont   (io_cont),
      .io_addr   (io_addr),
      .io_data   (io_data),
      .io_claim  (io_claim),
      .irq_lvl   (irq_lvl),
      .aux_data  (aux_data),
      .aux_valid (aux_valid)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] merge(input logic [15:0] cur, input logic [31:0] w);
      return (cur & w[31:16]) | (w[15:0] & ~w[31:16]);
   endfunction

   // one cycle of stimulus, with checks of the claim and of the registered outputs
   task automatic step(input logic wr, input logic cont, input logic [15:0] a,
                       input logic [31:0] d, input logic cwe, input logic [15:0] ca,
                       input string tag);
      logic first, second;
      @(negedge clk);
      io_wr = wr; io_cont = cont; io_addr = a; io_data = d;
      cfg_we = cwe; cfg_addr = ca;
      first  = wr && !cont && (a == m_addr);
      second = wr && cont && m_armed;
      #1;
      chk({tag, " claim"}, {31'd0, io_claim}, {31'd0, first || second});
      @(posedge clk);
      if (first) m_irq = merge(m_irq, d);
      m_auxv = second;
      if (second) m_aux = d;
      if (wr) m_armed = first;
      if (cwe) m_addr = ca;
      #1;
      chk({tag, " irq"}, {16'd0, irq_lvl}, {16'd0, m_irq});
      chk({tag, " auxv"}, {31'd0, aux_valid}, {31'd0, m_auxv});
      chk({tag, " auxd"}, aux_data, m_aux);
      io_wr = 1'b0; cfg_we = 1'b0;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20250101));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 irq", {16'd0, irq_lvl}, 32'd0);
      chk("R1 auxv", {31'd0, aux_valid}, 32'd0);
      chk("R1 auxd", aux_data, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset address is live; R2/R3 enabled line set
      step(1, 0, RST_ADDR, 32'hFFF7_0008, 0, 0, "R1 R2 R3 set line3");
      // R4: all enables high keep every line
      step(1, 0, RST_ADDR, 32'hFFFF_0000, 0, 0, "R4 all masked");
      // R3: clear line 3 while keeping others
      step(1, 0, RST_ADDR, 32'hFFF7_0000, 0, 0, "R3 clear line3");
      // R3: all lines enabled, pattern
      step(1, 0, RST_ADDR, 32'h0000_A5C3, 0, 0, "R3 full word");
      // R5: other address ignored
      step(1, 0, RST_ADDR + 16'd4, 32'h0000_0000, 0, 0, "R5 other addr");
      // R7: continuation after unclaimed write
      step(1, 1, RST_ADDR, 32'h1234_5678, 0, 0, "R7 orphan cont");
      // R6: second phase, then R7 third phase
      step(1, 0, RST_ADDR, 32'h00FF_1200, 0, 0, "R3 R4 first");
      step(0, 0, 0, 0, 0, 0, "R6 idle gap");
      step(1, 1, 16'h0000, 32'hDEAD_BEEF, 0, 0, "R6 second phase");
      step(1, 1, 16'h0000, 32'h0000_FFFF, 0, 0, "R7 third phase");
      // R9: no strobe, matching address
      step(0, 0, RST_ADDR, 32'h0000_FFFF, 0, 0, "R9 no strobe");
      // R8: same-cycle write uses old address, then new one takes effect
      step(1, 0, 16'h0300, 32'h0000_FFFF, 1, 16'h0300, "R8 old addr");
      step(1, 0, 16'h0300, 32'hFFFE_0001, 0, 0, "R8 new addr");
      step(1, 0, RST_ADDR, 32'h0000_0000, 0, 0, "R8 old addr dead");

      for (int i = 0; i < 4000; i++) begin
         logic [15:0] a;
         logic        cont;
         logic        cwe;
         a    = ($urandom % 4 != 0) ? m_addr : 16'($urandom);
         cont = ($urandom % 10) < 3;
         cwe  = ($urandom % 50) == 0;
         step(($urandom % 5) != 0, cont, a, $urandom, cwe,
              ($urandom % 2) ? m_addr ^ 16'h0010 : 16'($urandom), "R2 R3 R4 R5 R6 R7 R8 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule